// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Unit

This unit picks the smaller or larger of two floating-point operands held in 64-bit register words. It handles both single and double precision. One input chooses the precision and another chooses minimum or maximum. The result and an invalid-operation flag are registered, so they appear one clock after the operands are presented. The unit has no handshake, and a new operation can be issued every cycle.

The unit sorts out NaN operands, detects signaling NaNs and produces the canonical NaN. It orders negative zero below positive zero. For single precision it checks the NaN-boxing of each input and boxes the result: the upper half of the 64-bit word is all ones and the value sits in the lower half. When only one operand is a NaN, the unit returns the other operand, whether the NaN is quiet or signaling. A signaling NaN still raises the invalid flag in that case.

Top module: `fpmm_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `result` becomes 0 and `invalid` becomes 0 at that edge.
- R2: When neither operand is a NaN, `result` is the smaller operand when `want_max`=0 and the larger one when `want_max`=1. The result appears one cycle after the inputs are sampled.
- R3: When exactly one operand is a quiet NaN, `result` is the other operand. This holds for both minimum and maximum.
- R4: When exactly one operand is a signaling NaN, `result` is the other operand and `invalid` is 1.
- R5: `invalid` is 1 exactly when at least one effective operand is a signaling NaN. Quiet NaNs alone leave it at 0.
- R6: When both operands are NaN, `result` is the canonical NaN of the selected precision. For double precision this is 0x7FF8000000000000. For single precision it is 0xFFFFFFFF7FC00000.
- R7: Negative zero orders below positive zero. The minimum of (-0, +0) is -0 (0x8000000000000000 in double precision) and the maximum is +0.
- R8: When `is_single`=1, bits [63:32] of `result` are all ones and bits [31:0] hold the single-precision value.
- R9: A single-precision input whose bits [63:32] are not all ones is treated as the quiet NaN 0x7FC00000. On its own it does not raise `invalid`.
- R10: A value is a NaN when its exponent field is all ones and its mantissa is nonzero. Mantissa MSB 0 marks a signaling NaN and MSB 1 marks a quiet NaN. An all-ones exponent with a zero mantissa is an infinity, which is ordered as a number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 64 | First operand register word |
| op_b | input | 64 | Second operand register word |
| is_single | input | 1 | 1 selects single precision, 0 selects double |
| want_max | input | 1 | 1 selects maximum, 0 selects minimum |
| result | output | 64 | Registered result word |
| invalid | output | 1 | Registered invalid-operation flag |

## Verification
The assertions take for granted that `is_single` and both operands are stable and free of X values at each sampling edge. They also assume that one instruction's operands and selects arrive together. The bench drives every input on the falling edge and holds each operation for a full cycle. It reads `result` and `invalid` on the following falling edge, which is one register stage later. Single-precision stimulus includes deliberately mis-boxed words, so the canonical-substitution path is exercised and not only assumed.

// File: rtl/fpmm_pkg.sv
// Package: shared widths and canonical NaN constants for the min/max unit.
// Assumes IEEE binary32 and binary64 field layouts.
package fpmm_pkg;
    localparam int REG_W  = 64;
    localparam int DP_EXP = 11;
    localparam int DP_MAN = 52;
    localparam int SP_EXP = 8;
    localparam int SP_MAN = 23;
    localparam int SP_W   = 1 + SP_EXP + SP_MAN;
    localparam int BOX_W  = REG_W - SP_W;

    localparam logic [REG_W-1:0] DP_CANON = {1'b0, {DP_EXP{1'b1}}, 1'b1, {(DP_MAN-1){1'b0}}};
    localparam logic [SP_W-1:0]  SP_CANON = {1'b0, {SP_EXP{1'b1}}, 1'b1, {(SP_MAN-1){1'b0}}};
endpackage

// File: rtl/fpmm_classify.sv
// Module: classifies one floating-point value of a given format.
// Reports NaN, signaling NaN, zero and the sign. Purely combinational.
module fpmm_classify #(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    localparam int W = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] val,
    output logic         is_nan,
    output logic         is_snan,
    output logic         is_zero,
    output logic         sign
);
    logic exp_ones;

    // Purpose: decode the exponent and mantissa fields into class flags.
    always_comb begin
        exp_ones = &val[W-2:MAN_W];
        is_nan   = exp_ones && (val[MAN_W-1:0] != '0);
        is_snan  = is_nan && !val[MAN_W-1];
        is_zero  = (val[W-2:0] == '0);
        sign     = val[W-1];
    end
endmodule

// File: rtl/fpmm_pick.sv
// Module: chooses the minimum or maximum of two values of width W.
// NaN flags come from the caller. Both NaN gives the supplied canonical NaN.
// Exactly one NaN gives the other operand. Sign-magnitude ordering is used,
// so -0 orders below +0.
module fpmm_pick #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         nan_a,
    input  logic         nan_b,
    input  logic         want_max,
    input  logic [W-1:0] canon,
    output logic [W-1:0] res
);
    logic a_lt_b;
    logic take_a;

    // Purpose: order the operands, then apply the NaN rules to pick the result.
    always_comb begin
        a_lt_b = (a[W-1] && !b[W-1])
               || (!a[W-1] && !b[W-1] && (a[W-2:0] < b[W-2:0]))
               || (a[W-1] && b[W-1] && (a[W-2:0] > b[W-2:0]));
        take_a = want_max ? !a_lt_b : a_lt_b;
        if (nan_a && nan_b)
            res = canon;
        else if (nan_a)
            res = b;
        else if (nan_b)
            res = a;
        else
            res = take_a ? a : b;
    end
endmodule

// File: rtl/fpmm_unit.sv
// Module: top of the floating-point min/max unit, with a one-cycle registered result.
// Assumes the operands and selects are stable at the clock edge.
// Single-precision inputs are unboxed. A mis-boxed input becomes the canonical quiet NaN.
module fpmm_unit (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [63:0] op_a,
    input  logic [63:0] op_b,
    input  logic        is_single,
    input  logic        want_max,
    output logic [63:0] result,
    output logic        invalid
);
    import fpmm_pkg::*;

    logic [REG_W-1:0] opnd    [2];
    logic [SP_W-1:0]  sp_val  [2];
    logic             dp_nan  [2];
    logic             dp_snan [2];
    logic             dp_zero [2];
    logic             dp_sign [2];
    logic             sp_nan  [2];
    logic             sp_snan [2];
    logic             sp_zero [2];
    logic             sp_sign [2];
    logic             eff_nan [2];
    logic             eff_snan[2];
    logic             eff_zero[2];
    logic             eff_sign[2];

    assign opnd[0] = op_a;
    assign opnd[1] = op_b;

    for (genvar g = 0; g < 2; g++) begin : g_opnd
        // Purpose: unbox the single-precision value, substituting the canonical NaN.
        always_comb begin
            sp_val[g] = (&opnd[g][REG_W-1:SP_W]) ? opnd[g][SP_W-1:0] : SP_CANON;
        end

        fpmm_classify #(.EXP_W(DP_EXP), .MAN_W(DP_MAN)) u_cls_dp (
            .val(opnd[g]), .is_nan(dp_nan[g]), .is_snan(dp_snan[g]),
            .is_zero(dp_zero[g]), .sign(dp_sign[g])
        );

        fpmm_classify #(.EXP_W(SP_EXP), .MAN_W(SP_MAN)) u_cls_sp (
            .val(sp_val[g]), .is_nan(sp_nan[g]), .is_snan(sp_snan[g]),
            .is_zero(sp_zero[g]), .sign(sp_sign[g])
        );

        // Purpose: select the class flags of the active precision.
        always_comb begin
            eff_nan[g]  = is_single ? sp_nan[g]  : dp_nan[g];
            eff_snan[g] = is_single ? sp_snan[g] : dp_snan[g];
            eff_zero[g] = is_single ? sp_zero[g] : dp_zero[g];
            eff_sign[g] = is_single ? sp_sign[g] : dp_sign[g];
        end
    end

    logic [REG_W-1:0] dp_res;
    logic [SP_W-1:0]  sp_res;
    logic [REG_W-1:0] next_res;
    logic             next_inv;

    fpmm_pick #(.W(REG_W)) u_pick_dp (
        .a(op_a), .b(op_b), .nan_a(dp_nan[0]), .nan_b(dp_nan[1]),
        .want_max(want_max), .canon(DP_CANON), .res(dp_res)
    );

    fpmm_pick #(.W(SP_W)) u_pick_sp (
        .a(sp_val[0]), .b(sp_val[1]), .nan_a(sp_nan[0]), .nan_b(sp_nan[1]),
        .want_max(want_max), .canon(SP_CANON), .res(sp_res)
    );

    // Purpose: choose the precision path, box single results and form the invalid flag.
    always_comb begin
        next_res = is_single ? {{BOX_W{1'b1}}, sp_res} : dp_res;
        next_inv = eff_snan[0] || eff_snan[1];
    end

    // Purpose: register the result and flag, with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result  <= '0;
            invalid <= 1'b0;
        end else begin
            result  <= next_res;
            invalid <= next_inv;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (result == '0 && !invalid)); // R1
    AST_ONE_NAN_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_nan[0] && !eff_nan[1]) |=>
        result == $past(is_single ? {{BOX_W{1'b1}}, sp_val[1]} : op_b)); // R3
    AST_INVALID_SNAN: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> invalid == $past(eff_snan[0] || eff_snan[1])); // R5
    AST_BOTH_NAN_CANON: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_nan[0] && eff_nan[1] && !is_single) |=> result == DP_CANON); // R6
    AST_NEG_ZERO_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_zero[0] && eff_zero[1] && (eff_sign[0] != eff_sign[1]) && !want_max && !is_single)
        |=> result[REG_W-1]); // R7
    AST_SINGLE_BOXED: assert property (@(posedge clk) disable iff (!rst_n)
        is_single |=> (&result[REG_W-1:SP_W])); // R8
endmodule

// File: tb/tb_fpmm_unit.sv
// Directed bench for fpmm_unit. Each scenario task drives inputs on the falling edge
// and checks the registered outputs on the next falling edge.
module tb_fpmm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        is_single = 1'b0;
    logic        want_max = 1'b0;
    logic [63:0] result;
    logic        invalid;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fpmm_unit dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .is_single(is_single), .want_max(want_max),
        .result(result), .invalid(invalid)
    );

    localparam logic [63:0] D_ONE  = 64'h3FF0000000000000;
    localparam logic [63:0] D_TWO  = 64'h4000000000000000;
    localparam logic [63:0] D_M1   = 64'hBFF0000000000000;
    localparam logic [63:0] D_M3   = 64'hC008000000000000;
    localparam logic [63:0] D_QNAN = 64'h7FF8000000000001;
    localparam logic [63:0] D_SNAN = 64'h7FF0000000000001;
    localparam logic [63:0] D_INF  = 64'h7FF0000000000000;
    localparam logic [63:0] D_CAN  = 64'h7FF8000000000000;
    localparam logic [63:0] S_ONE  = 64'hFFFFFFFF3F800000;
    localparam logic [63:0] S_TWO  = 64'hFFFFFFFF40000000;
    localparam logic [63:0] S_SNAN = 64'hFFFFFFFF7F800001;
    localparam logic [63:0] S_CAN  = 64'hFFFFFFFF7FC00000;

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                          input logic sgl, input logic mx);
        @(negedge clk);
        op_a = a; op_b = b; is_single = sgl; want_max = mx;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        run_op(D_ONE, D_SNAN, 1'b0, 1'b0);
        chk("R1 result", result, 64'h0);
        chk("R1 invalid", {63'h0, invalid}, 64'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_numbers();
        run_op(D_ONE, D_TWO, 1'b0, 1'b0);
        chk("R2 min(1,2)", result, D_ONE);
        run_op(D_M3, D_TWO, 1'b0, 1'b1);
        chk("R2 max(-3,2)", result, D_TWO);
        run_op(D_M1, D_M3, 1'b0, 1'b0);
        chk("R2 min(-1,-3)", result, D_M3);
        chk("R5 numbers invalid", {63'h0, invalid}, 64'h0);
    endtask

    task automatic t_qnan();
        run_op(D_QNAN, D_ONE, 1'b0, 1'b0);
        chk("R3 min(qnan,1)", result, D_ONE);
        chk("R5 qnan invalid", {63'h0, invalid}, 64'h0);
        run_op(D_TWO, D_QNAN, 1'b0, 1'b1);
        chk("R3 max(2,qnan)", result, D_TWO);
    endtask

    task automatic t_snan();
        run_op(D_SNAN, D_TWO, 1'b0, 1'b1);
        chk("R4 max(snan,2)", result, D_TWO);
        chk("R4 invalid", {63'h0, invalid}, 64'h1);
        run_op(D_M1, D_SNAN, 1'b0, 1'b0);
        chk("R4 min(-1,snan)", result, D_M1);
        chk("R10 snan flagged", {63'h0, invalid}, 64'h1);
    endtask

    task automatic t_both_nan();
        run_op(D_QNAN, D_SNAN, 1'b0, 1'b0);
        chk("R6 canonical", result, D_CAN);
        chk("R5 snan+qnan invalid", {63'h0, invalid}, 64'h1);
        run_op(D_QNAN, D_QNAN, 1'b0, 1'b1);
        chk("R6 canonical qq", result, D_CAN);
        chk("R5 qq invalid", {63'h0, invalid}, 64'h0);
    endtask

    task automatic t_zero();
        run_op(64'h0, 64'h8000000000000000, 1'b0, 1'b0);
        chk("R7 min(+0,-0)", result, 64'h8000000000000000);
        run_op(64'h8000000000000000, 64'h0, 1'b0, 1'b1);
        chk("R7 max(-0,+0)", result, 64'h0);
    endtask

    task automatic t_inf();
        run_op(D_INF, D_ONE, 1'b0, 1'b0);
        chk("R10 min(inf,1)", result, D_ONE);
        run_op(D_INF, D_ONE, 1'b0, 1'b1);
        chk("R10 max(inf,1)", result, D_INF);
        chk("R10 inf invalid", {63'h0, invalid}, 64'h0);
    endtask

    task automatic t_single();
        run_op(S_ONE, S_TWO, 1'b1, 1'b1);
        chk("R8 max single", result, S_TWO);
        run_op(S_SNAN, S_ONE, 1'b1, 1'b0);
        chk("R8 single snan", result, S_ONE);
        chk("R4 single invalid", {63'h0, invalid}, 64'h1);
    endtask

    task automatic t_unboxed();
        run_op(64'h000000003F800000, S_TWO, 1'b1, 1'b0);
        chk("R9 misboxed", result, S_TWO);
        chk("R9 misboxed invalid", {63'h0, invalid}, 64'h0);
        run_op(64'h000000003F800000, 64'h7FFFFFFF40000000, 1'b1, 1'b1);
        chk("R9 both misboxed", result, S_CAN);
    endtask

    initial begin
        t_reset();
        t_numbers();
        t_qnan();
        t_snan();
        t_both_nan();
        t_zero();
        t_inf();
        t_single();
        t_unboxed();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule